// File: doc/BRIEF.md
# Slow-Domain Shadow Read Synchronizer

This block gives a fast bus clock domain a coherent, readable copy of the state held in a slow timekeeping domain that never stops. That state is a prescaler divider, a 32-bit counter, an alarm value and a few status flags. A slow-side holding stage captures the core's outputs on each rising slow-clock edge. The bus side watches the same slow clock through a synchronizer and an edge detector. When it sees a rising edge, it copies the holding stage into bus-side shadow registers.

A hardware-set synchronized flag tells software when the shadows can be trusted. The bus-side reset clears the flag and the shadows, so a read after the bus side comes back up returns zeros until the first refresh. The flag is set on each refresh. Software clears it by writing 0, which lets it wait for a fresh copy after a disable or reset.

The holding stage has its own backup reset, so the bus-side reset never clears the slow-side state.

Top module: `tk_shadow_sync`

## Requirements
- R1: While the bus-side reset is applied, and after it is released until the next refresh, every readable register reads zero, including the synchronized flag.
- R2: After each rising slow-clock edge, the shadows are refreshed within four bus cycles with the values present at the divider, counter, alarm and flag inputs at that edge.
- R3: Between refreshes, every shadow holds its value even when the slow-side inputs change.
- R4: Each rising slow-clock edge causes exactly one refresh, one bus cycle long.
- R5: Each refresh sets the synchronized flag.
- R6: Writing 0 to the synchronized flag clears it.
- R7: Writing 1 to the synchronized flag leaves it unchanged.
- R8: The backup reset clears the slow-side holding stage. While the backup reset is applied, refreshes deliver zero for divider, counter, alarm and flags.
- R9: The read address selects the register as follows.
  - Address 0 is status: bit 0 is the synchronized flag, bits FLAG_W:1 are the flags, and all other bits are zero.
  - Address 1 is the divider, zero-extended to the data width.
  - Address 2 is the counter.
  - Address 3 is the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-side asynchronous reset, active low |
| bkp_rst_ni | input | 1 | Slow-side backup asynchronous reset, active low |
| slow_clk_i | input | 1 | Slow timekeeping clock |
| div_i | input | DIV_W | Prescaler divider value from the timekeeping core |
| cnt_i | input | CNT_W | Counter value from the timekeeping core |
| alr_i | input | ALR_W | Alarm value from the timekeeping core |
| flags_i | input | FLAG_W | Status flags from the timekeeping core |
| addr_i | input | 2 | Read register select |
| sync_wr_i | input | 1 | Write strobe for the synchronized flag |
| sync_wdata_i | input | 1 | Write data for the synchronized flag (only 0 has an effect) |
| rd_data_o | output | DATA_W | Read data for the selected register |

## Verification
The hardest cases to reach are a bus-side reset or a flag clear that falls in the short gap after one refresh and before the next slow edge. The shadows must then stay at zero, or the flag must stay clear, with no second refresh from the same edge. The slow clock is chosen incommensurate with the bus clock, so edges drift across bus-clock phases. Each slow cycle is checked at its falling edge. Random actions (flag clear, write of 1, bus reset) then fall inside the remaining low phase, and a re-read before the next rising edge confirms that nothing moved. A directed pass holds the backup reset across several slow cycles and checks that zeros come through while the flag still sets.

// File: rtl/tk_shadow_pkg.sv
package tk_shadow_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_ALR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tk_slow_hold.sv
module tk_slow_hold #(
  parameter int DIV_W  = 20,
  parameter int CNT_W  = 32,
  parameter int ALR_W  = 32,
  parameter int FLAG_W = 3
) (
  input  logic              slow_clk_i,
  input  logic              bkp_rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ALR_W-1:0]  alr_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ALR_W-1:0]  alr_o,
  output logic [FLAG_W-1:0] flags_o
);
  // held a full slow period, so bus-side capture never sees bit skew
  always_ff @(posedge slow_clk_i or negedge bkp_rst_ni) begin
    if (!bkp_rst_ni) begin
      div_o   <= '0;
      cnt_o   <= '0;
      alr_o   <= '0;
      flags_o <= '0;
    end else begin
      div_o   <= div_i;
      cnt_o   <= cnt_i;
      alr_o   <= alr_i;
      flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/tk_edge_det.sv
module tk_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], async_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tk_shadow_regs.sv
module tk_shadow_regs #(
  parameter int DIV_W  = 20,
  parameter int CNT_W  = 32,
  parameter int ALR_W  = 32,
  parameter int FLAG_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ALR_W-1:0]  alr_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              sync_wr_i,
  input  logic              sync_wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ALR_W-1:0]  alr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o   <= '0;
      cnt_o   <= '0;
      alr_o   <= '0;
      flags_o <= '0;
    end else if (upd_i) begin
      div_o   <= div_i;
      cnt_o   <= cnt_i;
      alr_o   <= alr_i;
      flags_o <= flags_i;
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sync_o <= 1'b0;
    else if (upd_i)                       sync_o <= 1'b1;
    else if (sync_wr_i && !sync_wdata_i)  sync_o <= 1'b0;
  end

  // R3
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(div_o) && $stable(cnt_o) && $stable(alr_o) && $stable(flags_o)));
  // R5
  sync_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> sync_o);
  // R6
  sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_wr_i && !sync_wdata_i && !upd_i) |=> !sync_o);
  // R7
  sync_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_wr_i && sync_wdata_i && !upd_i) |=> $stable(sync_o));
endmodule

// File: rtl/tk_shadow_sync.sv
module tk_shadow_sync
  import tk_shadow_pkg::*;
#(
  parameter int DIV_W       = 20,
  parameter int CNT_W       = 32,
  parameter int ALR_W       = 32,
  parameter int FLAG_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bkp_rst_ni,
  input  logic              slow_clk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ALR_W-1:0]  alr_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [1:0]        addr_i,
  input  logic              sync_wr_i,
  input  logic              sync_wdata_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int STAT_W = FLAG_W + 1;

  logic [DIV_W-1:0]  hold_div, sh_div;
  logic [CNT_W-1:0]  hold_cnt, sh_cnt;
  logic [ALR_W-1:0]  hold_alr, sh_alr;
  logic [FLAG_W-1:0] hold_flags, sh_flags;
  logic              upd, sh_sync;
  logic [STAT_W-1:0] stat;

  tk_slow_hold #(.DIV_W(DIV_W), .CNT_W(CNT_W), .ALR_W(ALR_W), .FLAG_W(FLAG_W)) u_hold (
    .slow_clk_i (slow_clk_i),
    .bkp_rst_ni (bkp_rst_ni),
    .div_i      (div_i),
    .cnt_i      (cnt_i),
    .alr_i      (alr_i),
    .flags_i    (flags_i),
    .div_o      (hold_div),
    .cnt_o      (hold_cnt),
    .alr_o      (hold_alr),
    .flags_o    (hold_flags)
  );

  tk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (slow_clk_i),
    .rise_o  (upd)
  );

  tk_shadow_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W), .ALR_W(ALR_W), .FLAG_W(FLAG_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (upd),
    .div_i        (hold_div),
    .cnt_i        (hold_cnt),
    .alr_i        (hold_alr),
    .flags_i      (hold_flags),
    .sync_wr_i    (sync_wr_i),
    .sync_wdata_i (sync_wdata_i),
    .div_o        (sh_div),
    .cnt_o        (sh_cnt),
    .alr_o        (sh_alr),
    .flags_o      (sh_flags),
    .sync_o       (sh_sync)
  );

  assign stat = {sh_flags, sh_sync};

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_STAT: rd_data_o = DATA_W'(stat);
      SEL_DIV:  rd_data_o = DATA_W'(sh_div);
      SEL_CNT:  rd_data_o = DATA_W'(sh_cnt);
      SEL_ALR:  rd_data_o = DATA_W'(sh_alr);
      default:  rd_data_o = '0;
    endcase
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (sh_cnt == '0 && !sh_sync));
endmodule

// File: tb/tk_shadow_sync_test.sv
`timescale 1ns/1ps
module tk_shadow_sync_test;
  logic        clk = 1'b0, slow = 1'b0;
  logic        rst_n = 1'b0, bkp_n = 1'b0;
  logic [19:0] div_in = '0;
  logic [31:0] cnt_in = '0, alr_in = '0;
  logic [2:0]  flg_in = '0;
  logic [1:0]  addr = '0;
  logic        swr = 1'b0, swd = 1'b0;
  logic [31:0] rdata;

  logic [19:0] e_div;
  logic [31:0] e_cnt, e_alr;
  logic [2:0]  e_flg;
  logic        e_sync;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;
  always #97 slow = ~slow;

  tk_shadow_sync uut (
    .clk_i(clk), .rst_ni(rst_n), .bkp_rst_ni(bkp_n), .slow_clk_i(slow),
    .div_i(div_in), .cnt_i(cnt_in), .alr_i(alr_in), .flags_i(flg_in),
    .addr_i(addr), .sync_wr_i(swr), .sync_wdata_i(swd), .rd_data_o(rdata)
  );

  // model of what a correct refresh should carry
  always @(posedge slow or negedge bkp_n)
    if (!bkp_n) begin e_div <= '0; e_cnt <= '0; e_alr <= '0; e_flg <= '0; end
    else begin e_div <= div_in; e_cnt <= cnt_in; e_alr <= alr_in; e_flg <= flg_in; end

  function automatic logic [31:0] stat_word(input logic [2:0] f, input logic s);
    return {28'd0, f, s};
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit zero);
    logic [31:0] d;
    rd(2'd0, d); chk({tag, " stat"}, d, zero ? 32'd0 : stat_word(e_flg, e_sync));
    rd(2'd1, d); chk({tag, " div"},  d, zero ? 32'd0 : {12'd0, e_div});
    rd(2'd2, d); chk({tag, " cnt"},  d, zero ? 32'd0 : e_cnt);
    rd(2'd3, d); chk({tag, " alr"},  d, zero ? 32'd0 : e_alr);
  endtask

  task automatic check_sync(input string tag);
    logic [31:0] d;
    rd(2'd0, d); chk(tag, d, stat_word(e_flg, e_sync));
  endtask

  task automatic wr_sync(input logic v);
    swr = 1'b1; swd = v; @(negedge clk); swr = 1'b0; swd = 1'b0;
  endtask

  task automatic randomize_inputs();
    div_in = 20'($urandom); cnt_in = $urandom; alr_in = $urandom; flg_in = 3'($urandom);
  endtask

  task automatic checkpoint(input string tag);
    @(negedge slow); @(negedge clk); e_sync = 1'b1; check_all(tag, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    bit zero;
    void'($urandom(32'h5eed));
    randomize_inputs();
    e_sync = 1'b0;
    #50;
    check_all("R1 in reset", 1'b1);
    @(negedge clk); rst_n = 1'b1; bkp_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release", 1'b1);

    // directed: max-value and all-ones patterns, R9 mapping
    div_in = '1; cnt_in = '1; alr_in = 32'h0; flg_in = 3'b101;
    checkpoint("R2 first");
    div_in = 20'h00001; cnt_in = 32'h8000_0000; alr_in = '1; flg_in = 3'b010;
    checkpoint("R9 map");

    for (int i = 0; i < 300; i++) begin
      checkpoint("R2");
      randomize_inputs();
      zero = 1'b0;
      case ($urandom % 6)
        0: begin
          wr_sync(1'b0); e_sync = 1'b0; check_sync("R6 clear");
          repeat (3) @(negedge clk);
          check_sync("R4 no second refresh");
        end
        1: begin wr_sync(1'b1); check_sync("R7 write one"); end
        2: begin
          rst_n = 1'b0; @(negedge clk); check_all("R1 in reset", 1'b1);
          rst_n = 1'b1; @(negedge clk); e_sync = 1'b0;
          check_all("R1 after release", 1'b1); zero = 1'b1;
        end
        default: ;
      endcase
      @(negedge clk);
      check_all("R3 hold", zero);
    end

    // R8: backup reset clears the slow-side stage
    @(negedge clk); bkp_n = 1'b0;
    checkpoint("R8 under backup reset");
    randomize_inputs();
    checkpoint("R8 under backup reset");
    @(negedge clk); bkp_n = 1'b1;
    randomize_inputs();
    checkpoint("R8 after backup release");
    checkpoint("R2 after backup release");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule